// File: doc/BRIEF.md
# Per-Thread Program Counter Updater

This block holds and advances the fetch address of a single hardware thread in an interleaved multi-threaded core. One instance exists per thread. The thread scheduler pulses a slot strobe whenever it has consumed this thread's fetch slot. Only on that strobe does the fetch address move. The new address is either the next sequential word, a branch target, the trap vector base, or the saved exception PC.

Control-flow events may arrive in cycles when the thread does not own the fetch slot. They are captured in a small set of sticky flags, together with the most recent branch target. The captured events and any event presented in the slot cycle itself are merged and resolved by a fixed priority. After that slot, every captured event is dropped, including the ones that lost. Trap-cause encoding, control-register storage and branch comparison belong to other blocks.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is held asynchronously at the parameter `BOOT_ADDR` with bits [1:0] cleared.
- R2: In a cycle without `slot_i`, `pc_o` keeps its value. Any exception, interrupt, return or branch request seen in that cycle is captured and applied at the next slot.
- R3: At a slot with no effective event and `br_wait_i` low, `pc_o` advances by 4, wrapping modulo 2^32.
- R4: At a slot with an effective exception, `pc_o` becomes `trap_base_i` with bits [1:0] cleared.
- R5: An interrupt becomes effective when `irq_pend_i` is seen at or before the slot. A cycle with `irq_ack_i` high withdraws it, so it then has no effect. An effective interrupt loads `trap_base_i` with bits [1:0] cleared.
- R6: At a slot with an effective return-from-trap, `pc_o` becomes `epc_i` with bits [1:0] cleared.
- R7: At a slot with an effective branch, `pc_o` becomes the last `br_target_i` presented with `br_set_i` since the previous slot, with bits [1:0] cleared.
- R8: At a slot with `br_wait_i` high and no effective event, `pc_o` keeps its value.
- R9: The priority, from highest to lowest, is exception, interrupt, return, branch, branch-wait hold, and sequential increment.
- R10: Each slot clears all captured events, including those that lost arbitration.
- R11: Bits [1:0] of `pc_o` are zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_i | input | 1 | This thread's fetch slot was consumed this cycle |
| br_set_i | input | 1 | Branch taken request |
| br_target_i | input | 32 | Branch target address |
| br_wait_i | input | 1 | Branch outcome still unresolved; hold PC at slot |
| exc_set_i | input | 1 | Exception request |
| ret_set_i | input | 1 | Return-from-trap request |
| irq_pend_i | input | 1 | Interrupt pending |
| irq_ack_i | input | 1 | Interrupt served; withdraws a pending interrupt |
| trap_base_i | input | 32 | Trap vector base address |
| epc_i | input | 32 | Saved exception PC |
| pc_o | output | 32 | Current fetch address of the thread |

## Verification
The updater is driven with bare slot strobes to exercise sequential stepping, including the wrap past the top word. Each event type is presented both in the slot cycle and in idle cycles before it, which separates immediate resolution from captured resolution. Mixed bundles of events at one slot confirm the priority order. A captured return plus branch followed by a second slot shows that the losing branch is dropped, not deferred. Unaligned boot, vector, EPC and target values confirm that the low bits are cleared on every load path.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef struct packed {
    logic exc;
    logic irq;
    logic ret;
    logic br;
  } pcu_evt_t;

  typedef enum logic [2:0] {
    SEL_SEQ, SEL_HOLD, SEL_BR, SEL_RET, SEL_IRQ, SEL_EXC
  } pcu_sel_e;
endpackage

// File: rtl/pcu_evt_latch.sv
module pcu_evt_latch
  import pcu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slot_i,
  input  pcu_evt_t      raw_i,
  input  logic          irq_ack_i,
  input  logic [AW-1:0] br_target_i,
  output pcu_evt_t      eff_o,
  output logic [AW-1:0] tgt_o
);
  pcu_evt_t      flags_q;
  logic [AW-1:0] tgt_q;

  always_comb begin
    eff_o     = flags_q | raw_i;
    eff_o.irq = (flags_q.irq | raw_i.irq) & ~irq_ack_i;
    tgt_o     = raw_i.br ? br_target_i : tgt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      tgt_q   <= '0;
    end else begin
      flags_q <= slot_i ? '0 : eff_o;  // slot consumes everything
      if (raw_i.br) tgt_q <= br_target_i;
    end
  end

  p_drop_after_slot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i |=> (flags_q == '0));
endmodule

// File: rtl/pcu_target_sel.sv
module pcu_target_sel
  import pcu_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned ALIGN = 2
) (
  input  pcu_evt_t      eff_i,
  input  logic          hold_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [AW-1:0] trap_base_i,
  input  logic [AW-1:0] epc_i,
  output pcu_sel_e      sel_o,
  output logic [AW-1:0] next_o
);
  localparam logic [AW-1:0] STEP = AW'(1) << ALIGN;
  localparam logic [AW-1:0] MASK = ~((AW'(1) << ALIGN) - AW'(1));

  logic [AW-1:0] raw_next;

  always_comb begin
    if      (eff_i.exc) sel_o = SEL_EXC;
    else if (eff_i.irq) sel_o = SEL_IRQ;
    else if (eff_i.ret) sel_o = SEL_RET;
    else if (eff_i.br)  sel_o = SEL_BR;
    else if (hold_i)    sel_o = SEL_HOLD;
    else                sel_o = SEL_SEQ;

    unique case (sel_o)
      SEL_EXC, SEL_IRQ: raw_next = trap_base_i;
      SEL_RET:          raw_next = epc_i;
      SEL_BR:           raw_next = tgt_i;
      SEL_HOLD:         raw_next = pc_i;
      default:          raw_next = pc_i + STEP;
    endcase
    next_o = raw_next & MASK;
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int unsigned   AW        = 32,
  parameter logic [AW-1:0] BOOT_ADDR = 32'h0000_0100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slot_i,
  input  logic          br_set_i,
  input  logic [AW-1:0] br_target_i,
  input  logic          br_wait_i,
  input  logic          exc_set_i,
  input  logic          ret_set_i,
  input  logic          irq_pend_i,
  input  logic          irq_ack_i,
  input  logic [AW-1:0] trap_base_i,
  input  logic [AW-1:0] epc_i,
  output logic [AW-1:0] pc_o
);
  localparam int unsigned   ALIGN = 2;
  localparam logic [AW-1:0] MASK  = ~((AW'(1) << ALIGN) - AW'(1));
  localparam logic [AW-1:0] STEP  = AW'(1) << ALIGN;

  pcu_evt_t      raw, eff;
  pcu_sel_e      sel;
  logic [AW-1:0] tgt, next_pc, pc_q;

  assign raw = '{exc: exc_set_i, irq: irq_pend_i, ret: ret_set_i, br: br_set_i};

  pcu_evt_latch #(.AW(AW)) u_latch (
    .clk_i, .rst_ni, .slot_i, .raw_i(raw), .irq_ack_i, .br_target_i,
    .eff_o(eff), .tgt_o(tgt)
  );

  pcu_target_sel #(.AW(AW), .ALIGN(ALIGN)) u_sel (
    .eff_i(eff), .hold_i(br_wait_i), .pc_i(pc_q), .tgt_i(tgt),
    .trap_base_i, .epc_i, .sel_o(sel), .next_o(next_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= BOOT_ADDR & MASK;
    else if (slot_i) pc_q <= next_pc;
  end

  assign pc_o = pc_q;

  p_idle_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> $stable(pc_q));
  p_seq_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && eff == '0 && !br_wait_i) |=> (pc_q == $past(pc_q) + STEP));
  p_exc_vector_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && exc_set_i) |=> (pc_q == ($past(trap_base_i) & MASK)));
  p_ret_epc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && ret_set_i && !eff.exc && !eff.irq) |=> (pc_q == ($past(epc_i) & MASK)));
  p_wait_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && br_wait_i && eff == '0) |=> $stable(pc_q));
  p_aligned_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[1:0] == 2'b00);
endmodule

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
  localparam logic [31:0] BOOT = 32'h0000_0103;
  localparam logic [31:0] TVEC = 32'h0000_0803;
  localparam logic [31:0] EPC  = 32'h0000_2222;

  logic        clk = 0, rst_n = 0;
  logic        slot = 0, br = 0, bw = 0, exc = 0, ret = 0, irq = 0, ack = 0;
  logic [31:0] tgt = 0, pc;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pc_next_unit #(.BOOT_ADDR(BOOT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .slot_i(slot), .br_set_i(br), .br_target_i(tgt),
    .br_wait_i(bw), .exc_set_i(exc), .ret_set_i(ret), .irq_pend_i(irq),
    .irq_ack_i(ack), .trap_base_i(TVEC), .epc_i(EPC), .pc_o(pc)
  );

  task automatic chk(input string req, input logic [31:0] exp);
    n_chk++;
    if (pc !== exp) begin
      n_bad++;
      $display("FAIL %s: pc=%h expected=%h", req, pc, exp);
    end
  endtask

  // one cycle of stimulus, driven at negedge, back at the next negedge
  task automatic cyc(input logic s, input logic e, input logic i, input logic a,
                     input logic r, input logic b, input logic [31:0] t, input logic w);
    slot = s; exc = e; irq = i; ack = a; ret = r; br = b; tgt = t; bw = w;
    @(negedge clk);
    slot = 0; exc = 0; irq = 0; ack = 0; ret = 0; br = 0; bw = 0;
  endtask

  task automatic t_reset;
    chk("R1 boot", 32'h100);
    chk("R11 boot align", 32'h100);
  endtask

  task automatic t_seq;
    cyc(1,0,0,0,0,0,0,0); chk("R3 step1", 32'h104);
    cyc(1,0,0,0,0,0,0,0); chk("R3 step2", 32'h108);
    cyc(1,0,0,0,0,1,32'hFFFF_FFFF,0); chk("R7 R11 target align", 32'hFFFF_FFFC);
    cyc(1,0,0,0,0,0,0,0); chk("R3 wrap", 32'h0);
  endtask

  task automatic t_exc;
    cyc(0,1,0,0,0,0,0,0); chk("R2 no slot", 32'h0);
    cyc(0,0,0,0,0,0,0,0); chk("R2 still held", 32'h0);
    cyc(1,0,0,0,0,0,0,0); chk("R4 latched exc", 32'h800);
    cyc(1,1,0,0,0,0,0,0); chk("R4 direct exc", 32'h800);
  endtask

  task automatic t_irq;
    cyc(0,0,1,0,0,0,0,0);
    cyc(0,0,0,1,0,0,0,0);
    cyc(1,0,0,0,0,0,0,0); chk("R5 acked irq ignored", 32'h804);
    cyc(1,0,1,0,0,0,0,0); chk("R5 irq taken", 32'h800);
    cyc(1,0,1,1,0,0,0,0); chk("R5 irq acked same cycle", 32'h804);
  endtask

  task automatic t_ret;
    cyc(1,0,0,0,1,0,0,0); chk("R6 return", 32'h2220);
  endtask

  task automatic t_branch;
    cyc(0,0,0,0,0,1,32'h4000,0);
    cyc(0,0,0,0,0,1,32'h5002,0); chk("R2 branch held", 32'h2220);
    cyc(1,0,0,0,0,0,0,0); chk("R7 last target", 32'h5000);
  endtask

  task automatic t_wait;
    cyc(1,0,0,0,0,0,0,1); chk("R8 wait holds", 32'h5000);
    cyc(1,0,0,0,0,1,32'h6000,1); chk("R9 branch over wait", 32'h6000);
  endtask

  task automatic t_prio;
    cyc(1,1,1,0,1,1,32'h7000,1); chk("R9 exc wins", 32'h800);
    cyc(1,0,1,0,1,1,32'h7000,0); chk("R9 irq over ret", 32'h800);
    cyc(1,0,0,0,1,1,32'h7000,0); chk("R9 ret over br", 32'h2220);
  endtask

  task automatic t_clear;
    cyc(0,0,0,0,1,0,0,0);
    cyc(0,0,0,0,0,1,32'h9000,0);
    cyc(1,0,0,0,0,0,0,0); chk("R10 ret applied", 32'h2220);
    cyc(1,0,0,0,0,0,0,0); chk("R10 branch dropped", 32'h2224);
  endtask

  task automatic t_rerst;
    #3 rst_n = 0; #2; chk("R1 async reset", 32'h100);
    @(negedge clk); rst_n = 1;
    cyc(1,0,0,0,0,0,0,0); chk("R3 after reset", 32'h104);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset; t_seq; t_exc; t_irq; t_ret; t_branch; t_wait; t_prio; t_clear; t_rerst;
      end
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: timeout expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule